// File: doc/BRIEF.md
# Field memory write-enable generator

This block produces the strobes that let one video field memory capture picture data. Running on the acquisition pixel clock, it counts pixels from each rising edge of the horizontal reference and lines from each rising edge of the vertical sync. It forms a composite write-enable that is high only inside both a horizontal pixel window and a vertical line window. The horizontal part of that window can be delayed by zero to three pixel clocks. An input-enable strobe is also produced, together with a vertical blanking pulse that is used when the memory is fed by an external write-enable.

Three modes change the write-enable. In progressive mode every second field is skipped. In external mode the write-enable follows an input pin, and the internal windows and the delay are ignored. The still picture freeze holds both strobes low until a release strobe arrives. Window bounds and mode bits are loaded through a simple synchronous write port. They are held in shadow registers and take effect only at a vertical sync, so a field is never written with a half-changed window.

Top module: `field_wr_strobe`

## Requirements
- R1: During and right after reset, `we_o` is 0, `ie_o` is 1 and `vblank_o` is 1. All applied window bounds and control bits are 0.
- R2: The line count becomes 0 in the cycle after a sampled rising edge of `vsync_i`. It grows by one in the cycle after each sampled rising edge of `href_i`, and the vertical edge wins if both occur. A field flag starts at 0 and toggles on each vertical rising edge.
- R3: The pixel index becomes 0 in the cycle after a sampled rising edge of `href_i`, then grows by one each cycle. `we_o` is registered. It is high when the pixel index of the previous cycle lies in [hstart, hstop) and the line count lies in [vstart, vstop).
- R4: Control bits [1:0] (address 6) select a delay of 0, 1, 2 or 3 pixel clocks. The delay applies to the horizontal window term only, not to the line window.
- R5: When control bit 3 (address 6) is set, `we_o` equals `ext_we_i` from one cycle earlier. The windows and the delay have no effect.
- R6: When control bit 3 is set, `vblank_o` is low while the line count lies in [bstart, bstop) and high otherwise. When the bit is clear, `vblank_o` stays high.
- R7: When control bit 2 (address 6) is set and external mode is off, `we_o` is held low for every field in which the field flag is 1.
- R8: A pulse on `still_set_i` enters still mode from the next cycle. While still mode is active, `we_o` and `ie_o` are low, in every mode.
- R9: A pulse on `still_rel_i` leaves still mode. If set and release arrive together, set wins. A release while still mode is inactive has no effect.
- R10: Register writes land in shadow registers. They are copied to the applied set only at a sampled rising edge of `vsync_i`. A write in that same cycle waits for the following vertical edge.
- R11: The address map is 0 hstart, 1 hstop, 2 vstart, 3 vstop, 4 bstart, 5 bstop and 6 control. A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition pixel clock |
| rst_n | input | 1 | Active-low reset |
| href_i | input | 1 | Horizontal reference, rising edge starts a line |
| vsync_i | input | 1 | Vertical sync, rising edge starts a field |
| ext_we_i | input | 1 | External write-enable used in external mode |
| still_set_i | input | 1 | Pulse that enters still mode |
| still_rel_i | input | 1 | Pulse that leaves still mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | VAL_W | Register write data |
| we_o | output | 1 | Composite write-enable to the field memory |
| ie_o | output | 1 | Input-enable to the field memory |
| vblank_o | output | 1 | Vertical blanking pulse, active low |

## Verification
The bench drives whole fields of synthetic lines through a fixed window. It then reruns them with the delay at 1, 2 and 3, which shows whether only the horizontal term shifts and whether it shifts by the selected amount. Progressive fields separate skipped from written fields by the field flag. External fields use a random external enable, so windowed output can be told apart from pass-through output and the blanking span can be checked. Still set and release pulses, including coincident pulses and releases while idle, are placed mid-line. A write during the vertical sync cycle, and one to the unused address, show whether configuration changes only at the field boundary.

// File: rtl/fws_pkg.sv
`timescale 1ns/1ps
package fws_pkg;
  localparam int SPAN_W    = 16;
  localparam int NUM_VALS  = 6;
  localparam int CTRL_ADDR = 6;

  typedef enum int {
    RI_HSTART = 0,
    RI_HSTOP  = 1,
    RI_VSTART = 2,
    RI_VSTOP  = 3,
    RI_BSTART = 4,
    RI_BSTOP  = 5
  } reg_idx_e;

  // half-open span test: lo <= pos < hi
  function automatic logic in_span(input logic [SPAN_W-1:0] pos,
                                   input logic [SPAN_W-1:0] lo,
                                   input logic [SPAN_W-1:0] hi);
    return (pos >= lo) && (pos < hi);
  endfunction
endpackage

// File: rtl/fws_regs.sv
`timescale 1ns/1ps
module fws_regs #(
  parameter int VAL_W  = 11,
  parameter int DLY_W  = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [VAL_W-1:0]  wr_data_i,
  input  logic              apply_i,
  output logic [VAL_W-1:0]  val_o [fws_pkg::NUM_VALS],
  output logic [DLY_W-1:0]  dly_o,
  output logic              prog_o,
  output logic              ext_o
);
  localparam int NV     = fws_pkg::NUM_VALS;
  localparam int CTRL_W = DLY_W + 2;

  logic [VAL_W-1:0]  pend_q [NV];
  logic [VAL_W-1:0]  act_q  [NV];
  logic [CTRL_W-1:0] ctrl_pend_q, ctrl_act_q;
  logic              ctrl_hit;

  assign ctrl_hit = wr_en_i && (wr_addr_i == ADDR_W'(fws_pkg::CTRL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NV; k++) begin
        pend_q[k] <= '0;
        act_q[k]  <= '0;
      end
      ctrl_pend_q <= '0;
      ctrl_act_q  <= '0;
    end else begin
      if (apply_i) begin
        for (int k = 0; k < NV; k++) act_q[k] <= pend_q[k];
        ctrl_act_q <= ctrl_pend_q;
      end
      for (int k = 0; k < NV; k++)
        if (wr_en_i && (wr_addr_i == ADDR_W'(k))) pend_q[k] <= wr_data_i;
      if (ctrl_hit) ctrl_pend_q <= wr_data_i[CTRL_W-1:0];
    end
  end

  generate
    for (genvar g = 0; g < NV; g++) begin : g_out
      assign val_o[g] = act_q[g];
    end
  endgenerate

  assign dly_o  = ctrl_act_q[DLY_W-1:0];
  assign prog_o = ctrl_act_q[DLY_W];
  assign ext_o  = ctrl_act_q[DLY_W+1];

  // R10: applied configuration only moves at a field boundary
  p_hold_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |=> $stable(ctrl_act_q) && $stable(act_q[fws_pkg::RI_VSTART])
                 && $stable(act_q[fws_pkg::RI_HSTART]));
endmodule

// File: rtl/fws_timebase.sv
`timescale 1ns/1ps
module fws_timebase #(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              href_i,
  input  logic              vsync_i,
  output logic              vs_rise_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic href_q, vs_q;
  logic href_rise, vs_rise;
  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;
  logic              field_q;

  assign href_rise = href_i && !href_q;
  assign vs_rise   = vsync_i && !vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      href_q  <= 1'b0;
      vs_q    <= 1'b0;
      pix_q   <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
    end else begin
      href_q <= href_i;
      vs_q   <= vsync_i;
      if (href_rise)             pix_q <= '0;
      else if (pix_q != PIX_MAX) pix_q <= pix_q + 1'b1;
      if (vs_rise)                               line_q <= '0;
      else if (href_rise && line_q != LINE_MAX)  line_q <= line_q + 1'b1;
      if (vs_rise) field_q <= !field_q;
    end
  end

  assign vs_rise_o = vs_rise;
  assign pix_o     = pix_q;
  assign line_o    = line_q;
  assign field_o   = field_q;

  // R2: line count restarts on the vertical edge
  p_line_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (line_q == '0));
  // R2: line count steps once per horizontal edge
  p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (href_rise && !vs_rise && line_q != LINE_MAX) |=> (line_q == $past(line_q) + 1'b1));
  // R2: field flag flips on each vertical edge
  p_field_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (field_q != $past(field_q)));
endmodule

// File: rtl/fws_compose.sv
`timescale 1ns/1ps
module fws_compose #(
  parameter int PIX_W   = 11,
  parameter int LINE_W  = 10,
  parameter int VAL_W   = 11,
  parameter int MAX_DLY = 3,
  parameter int DLY_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_i,
  input  logic [VAL_W-1:0]  hs_i,
  input  logic [VAL_W-1:0]  he_i,
  input  logic [VAL_W-1:0]  vs_i,
  input  logic [VAL_W-1:0]  ve_i,
  input  logic [VAL_W-1:0]  bs_i,
  input  logic [VAL_W-1:0]  be_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic              prog_i,
  input  logic              ext_i,
  input  logic              ext_we_i,
  input  logic              still_set_i,
  input  logic              still_rel_i,
  output logic              we_o,
  output logic              ie_o,
  output logic              vblank_o
);
  import fws_pkg::*;

  logic h_now, h_sel, v_now, b_now, skip_now, win_we, we_next;
  logic [MAX_DLY-1:0] hp_q;
  logic still_q, we_q, ie_q, bl_q;

  assign h_now = in_span(SPAN_W'(pix_i),  SPAN_W'(hs_i), SPAN_W'(he_i));
  assign v_now = in_span(SPAN_W'(line_i), SPAN_W'(vs_i), SPAN_W'(ve_i));
  assign b_now = in_span(SPAN_W'(line_i), SPAN_W'(bs_i), SPAN_W'(be_i));

  // horizontal delay line, one stage per selectable delay step
  generate
    for (genvar g = 0; g < MAX_DLY; g++) begin : g_hdly
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) hp_q[g] <= 1'b0;
          else        hp_q[g] <= h_now;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) hp_q[g] <= 1'b0;
          else        hp_q[g] <= hp_q[g-1];
      end
    end
  endgenerate

  always_comb begin
    h_sel = h_now;
    for (int k = 1; k <= MAX_DLY; k++)
      if (int'(dly_i) == k) h_sel = hp_q[k-1];
  end

  assign skip_now = prog_i && field_i;
  assign win_we   = h_sel && v_now && !skip_now;

  always_comb begin
    if (still_q)    we_next = 1'b0;
    else if (ext_i) we_next = ext_we_i;
    else            we_next = win_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      still_q <= 1'b0;
      we_q    <= 1'b0;
      ie_q    <= 1'b1;
      bl_q    <= 1'b1;
    end else begin
      if (still_set_i)      still_q <= 1'b1;
      else if (still_rel_i) still_q <= 1'b0;
      we_q <= we_next;
      ie_q <= !still_q;
      bl_q <= !(ext_i && b_now);
    end
  end

  assign we_o     = we_q;
  assign ie_o     = ie_q;
  assign vblank_o = bl_q;

  // R8: freeze holds both strobes low
  p_still_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    still_q |=> (!we_o && !ie_o));
  // R5: external mode passes the pin through
  p_ext_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_i && !still_q) |=> (we_o == $past(ext_we_i)));
  // R7: skipped fields never write
  p_prog_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_i && field_i && !ext_i) |=> !we_o);
  // R9: a lone release cannot start a freeze
  p_rel_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!still_q && !still_set_i) |=> !still_q);
  // R6: no blanking outside external mode
  p_blank_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_i |=> vblank_o);
endmodule

// File: rtl/field_wr_strobe.sv
`timescale 1ns/1ps
module field_wr_strobe #(
  parameter int VAL_W   = 11,
  parameter int PIX_W   = 11,
  parameter int LINE_W  = 10,
  parameter int MAX_DLY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             href_i,
  input  logic             vsync_i,
  input  logic             ext_we_i,
  input  logic             still_set_i,
  input  logic             still_rel_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [VAL_W-1:0] wr_data_i,
  output logic             we_o,
  output logic             ie_o,
  output logic             vblank_o
);
  import fws_pkg::*;
  localparam int DLY_W = $clog2(MAX_DLY + 1);

  logic              vs_rise;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;
  logic              field;
  logic [VAL_W-1:0]  vals [NUM_VALS];
  logic [DLY_W-1:0]  dly;
  logic              prog, ext;

  fws_timebase #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .href_i(href_i), .vsync_i(vsync_i),
    .vs_rise_o(vs_rise), .pix_o(pix), .line_o(line), .field_o(field)
  );

  fws_regs #(.VAL_W(VAL_W), .DLY_W(DLY_W), .ADDR_W(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .apply_i(vs_rise), .val_o(vals),
    .dly_o(dly), .prog_o(prog), .ext_o(ext)
  );

  fws_compose #(.PIX_W(PIX_W), .LINE_W(LINE_W), .VAL_W(VAL_W),
                .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .pix_i(pix), .line_i(line), .field_i(field),
    .hs_i(vals[RI_HSTART]), .he_i(vals[RI_HSTOP]),
    .vs_i(vals[RI_VSTART]), .ve_i(vals[RI_VSTOP]),
    .bs_i(vals[RI_BSTART]), .be_i(vals[RI_BSTOP]),
    .dly_i(dly), .prog_i(prog), .ext_i(ext), .ext_we_i(ext_we_i),
    .still_set_i(still_set_i), .still_rel_i(still_rel_i),
    .we_o(we_o), .ie_o(ie_o), .vblank_o(vblank_o)
  );
endmodule

// File: tb/field_wr_strobe_test.sv
`timescale 1ns/1ps
module field_wr_strobe_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic href = 0, vsync = 0, ext_we = 0, sset = 0, srel = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [10:0] wr_data = 0;
  logic we, ie, vbl;
  int checks = 0, errors = 0;
  bit done = 0;
  bit rand_ext = 0;
  string cur_req = "R3";
  int we_high = 0;

  // behavioural reference state
  int m_pix, m_line, m_field, m_still, m_hq, m_vq;
  int pend[7], act[7];
  bit hist[$];
  bit e_we, e_ie, e_bl;

  always #2.5 clk = ~clk;

  field_wr_strobe uut (
    .clk(clk), .rst_n(rst_n), .href_i(href), .vsync_i(vsync), .ext_we_i(ext_we),
    .still_set_i(sset), .still_rel_i(srel), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .we_o(we), .ie_o(ie), .vblank_o(vbl)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic model_clock();
    int hr, vr, dly, prog, ext;
    bit hnow, hsel, vnow, bnow;
    hr = (href && !m_hq) ? 1 : 0;
    vr = (vsync && !m_vq) ? 1 : 0;
    dly = act[6] & 3; prog = (act[6] >> 2) & 1; ext = (act[6] >> 3) & 1;
    hnow = (m_pix >= act[0]) && (m_pix < act[1]);
    hsel = (dly == 0) ? hnow : hist[dly-1];
    vnow = (m_line >= act[2]) && (m_line < act[3]);
    bnow = (m_line >= act[4]) && (m_line < act[5]);
    if (m_still != 0) e_we = 0;
    else if (ext != 0) e_we = ext_we;
    else e_we = hsel && vnow && !(prog != 0 && m_field != 0);
    e_ie = (m_still == 0);
    e_bl = !(ext != 0 && bnow);
    hist.push_front(hnow); void'(hist.pop_back());
    if (hr != 0) m_pix = 0; else if (m_pix < 2047) m_pix++;
    if (vr != 0) m_line = 0; else if (hr != 0 && m_line < 1023) m_line++;
    if (vr != 0) m_field ^= 1;
    if (sset) m_still = 1; else if (srel) m_still = 0;
    if (vr != 0) for (int k = 0; k < 7; k++) act[k] = pend[k];
    if (wr_en && wr_addr < 6) pend[wr_addr] = int'(wr_data);
    if (wr_en && wr_addr == 6) pend[6] = int'(wr_data) & 15;
    m_hq = href; m_vq = vsync;
  endtask

  task automatic step(input logic h, input logic v);
    @(negedge clk);
    href = h; vsync = v;
    if (rand_ext) ext_we = 1'($urandom % 2);
    model_clock();
    @(posedge clk); #1;
    chk(cur_req, "we", we, e_we);
    chk("R8", "ie", ie, e_ie);
    chk("R6", "vblank", vbl, e_bl);
    if (we) we_high++;
    wr_en = 0; sset = 0; srel = 0;
  endtask

  task automatic wreg(input int a, input int d, input logic v);
    wr_en = 1; wr_addr = 3'(a); wr_data = 11'(d);
    step(0, v);
  endtask

  task automatic run_field(input int lines);
    step(0, 1); step(0, 1); step(0, 0);
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < 16; p++) step(p < 8, 0);
  endtask

  initial begin
    m_pix = 0; m_line = 0; m_field = 0; m_still = 0; m_hq = 0; m_vq = 0;
    for (int k = 0; k < 7; k++) begin pend[k] = 0; act[k] = 0; end
    for (int k = 0; k < 3; k++) hist.push_back(0);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1", "we in reset", we, 0);
    chk("R1", "ie in reset", ie, 1);
    chk("R1", "vblank in reset", vbl, 1);
    @(negedge clk); rst_n = 1;
    // R11: address map, all written between fields
    wreg(0, 3, 0); wreg(1, 9, 0); wreg(2, 2, 0); wreg(3, 5, 0);
    wreg(4, 1, 0); wreg(5, 4, 0); wreg(6, 0, 0);
    wreg(7, 5, 0); // R11: unused address ignored
    // R10: nothing applied yet, first field still closed
    cur_req = "R10"; we_high = 0;
    for (int p = 0; p < 40; p++) step(p % 16 < 8, 0);
    chk("R10", "we highs before apply", we_high, 0);
    cur_req = "R3"; we_high = 0;
    run_field(8); run_field(8);
    chk("R3", "we highs after apply", we_high, 2 * 3 * 6);
    cur_req = "R2"; run_field(3);
    // R4: each delay step
    for (int d = 1; d <= 3; d++) begin
      cur_req = "R4";
      wreg(6, d, 0);
      run_field(7);
    end
    // R10: write during vertical edge waits a field
    cur_req = "R10";
    wreg(6, 4, 1); step(0, 1);
    for (int l = 0; l < 6; l++) for (int p = 0; p < 16; p++) step(p < 8, 0);
    // R7: progressive skipping over several fields
    cur_req = "R7";
    run_field(6); run_field(6); run_field(6);
    // R5 / R6: external mode with random pin
    cur_req = "R5";
    wreg(6, 8, 0); rand_ext = 1;
    run_field(6); run_field(6);
    rand_ext = 0; ext_we = 0;
    // R8 / R9: freeze and release in windowed mode
    cur_req = "R8";
    wreg(6, 0, 0); run_field(2);
    for (int p = 0; p < 20; p++) begin
      if (p == 4) sset = 1;
      step(p % 16 < 8, 0);
    end
    cur_req = "R9";
    srel = 1; step(1, 0);
    for (int p = 0; p < 20; p++) step(p % 16 < 8, 0);
    srel = 1; step(0, 0); // R9: release while idle has no effect
    sset = 1; srel = 1; step(0, 0); // R9: set wins over release
    step(0, 0);
    chk("R9", "ie after coincident set/release", ie, 0);
    srel = 1; step(0, 0); step(0, 0);
    chk("R9", "ie after release", ie, 1);
    cur_req = "R3"; run_field(6);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule